// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks the column addresses of one read or write burst for a synchronous DRAM controller. A start strobe loads a 9-bit starting column, a 3-bit length code and an ordering bit. From the next cycle the block presents beat 0, which is always the starting column. Each step strobe then moves it on by one beat. Addresses wrap inside the burst-aligned block, and the upper column bits never change during a fixed-length burst.

Two orderings are supported. In linear ordering the low bits count upward, modulo the burst length. In XOR ordering the low bits are the start bits XOR-ed with the beat number. A full-page mode runs through all 512 columns, wrapping from the top column to zero, until a halt arrives or a new burst is started. A halt ends a burst at once. A start on any cycle replaces the burst in progress, so back-to-back column commands need no idle cycle between them.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block becomes idle after that edge: `busy_o`, `final_o` and `bad_len_o` are all 0.
- R2: A `start_i` sampled at an edge makes `busy_o` 1 and `col_o` equal to the sampled `col_start_i` after that edge. This is beat 0, whatever the ordering.
- R3: With `xor_order_i`=0 and burst length BL, beat n outputs the upper column bits of the start unchanged. The low log2(BL) bits are (start + n) mod BL.
- R4: With `xor_order_i`=1 and burst length BL, beat n outputs the upper column bits of the start unchanged. The low log2(BL) bits are the start's low bits XOR n.
- R5: `len_sel_i` codes 000, 001, 010 and 011 select 1, 2, 4 and 8 beats. `final_o` is 1 exactly on beat BL-1. A step taken on that beat makes `busy_o` 0 after the edge.
- R6: Code 111 with `xor_order_i`=0 is full page. The column rises by one on each step, wraps from 511 to 0, and `final_o` never rises.
- R7: `halt_i` during a burst makes `busy_o` 0 after the edge, and it wins over a step in the same cycle. A later `start_i` wins over `halt_i`.
- R8: `start_i` during a burst replaces it. The new start column is beat 0 after the edge, even when `step_i` or `halt_i` is high in the same cycle.
- R9: The reserved codes (100, 101, 110, and 111 with `xor_order_i`=1) run as a one-beat burst and set `bad_len_o` to 1. `bad_len_o` holds until the next start, and a start with a valid code clears it.
- R10: While busy with `step_i`, `halt_i` and `start_i` all low, `col_o` and `busy_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new burst with the fields below |
| col_start_i | input | 9 | Starting column of the burst |
| len_sel_i | input | 3 | Burst length code |
| xor_order_i | input | 1 | 0 = linear ordering, 1 = XOR ordering |
| step_i | input | 1 | Move to the next beat |
| halt_i | input | 1 | End the current burst |
| busy_o | output | 1 | A burst is in progress; `col_o` is valid |
| col_o | output | 9 | Column address of the current beat |
| final_o | output | 1 | Current beat is the last of a fixed-length burst |
| bad_len_o | output | 1 | The latest burst used a reserved length code |

## Verification
Three commands can meet on one edge. A step can coincide with a halt, and a new start can coincide with a step, a halt or both. The bench raises these strobes together in the middle of a linear burst and in the middle of a full-page burst. It then checks the cycle after the edge: the halt alone must leave the block idle, and the start must present its own column as beat 0 with the error flag from its own length code. Every burst in the vector table also lets the last-beat step end the burst, which confirms that a natural end and an explicit halt reach the same idle state.

// File: rtl/burst_pkg.sv
// Package: burst_pkg
// Shared encodings for the burst column address generator.
// Assumes the 3-bit length code and 1-bit order select given in the brief.
package burst_pkg;

    // Length selection codes; any other value is reserved.
    typedef enum logic [2:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

    // Beat ordering inside the aligned block.
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

endpackage

// File: rtl/burst_len_decode.sv
// Module: burst_len_decode
// Turns a length code and an order bit into a wrap mask (BL-1), a full-page
// flag and a reserved-code flag. Purely combinational.
// Assumes COL_W >= 3 so that an 8-beat mask fits.
module burst_len_decode
    import burst_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              order_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              full_o,
    output logic              bad_o
);

    localparam logic [COL_W-1:0] MASK_TWO   = COL_W'(1);
    localparam logic [COL_W-1:0] MASK_FOUR  = COL_W'(3);
    localparam logic [COL_W-1:0] MASK_EIGHT = COL_W'(7);

    // Map each code to its wrap mask; reserved codes fall back to one beat.
    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        bad_o  = 1'b0;
        case (code_i)
            LEN_ONE:   mask_o = '0;
            LEN_TWO:   mask_o = MASK_TWO;
            LEN_FOUR:  mask_o = MASK_FOUR;
            LEN_EIGHT: mask_o = MASK_EIGHT;
            LEN_PAGE: begin
                if (order_i == ORD_LINEAR) begin
                    full_o = 1'b1;
                    mask_o = '1;
                end else begin
                    bad_o = 1'b1;
                end
            end
            default:   bad_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Holds the state of the running burst: start column, wrap mask, order,
// full-page and reserved flags, and the beat counter.
// Start wins over halt, and halt wins over step. The counter wraps naturally
// at COL_W bits, which gives full-page wrap from the top column to zero.
module burst_beat_ctr #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             halt_i,
    input  logic [COL_W-1:0] col_start_i,
    input  logic             order_i,
    input  logic [COL_W-1:0] dec_mask_i,
    input  logic             dec_full_i,
    input  logic             dec_bad_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic             order_o,
    output logic             full_o,
    output logic             bad_o,
    output logic             last_o
);

    localparam logic [COL_W-1:0] BEAT_ONE = COL_W'(1);

    logic             active_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             order_q;
    logic             full_q;
    logic             bad_q;
    logic             at_end;

    // Last beat of a fixed-length burst.
    always_comb begin
        at_end = active_q && !full_q && (beat_q == mask_q);
    end

    // Burst configuration: captured only on a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            mask_q  <= '0;
            order_q <= 1'b0;
            full_q  <= 1'b0;
            bad_q   <= 1'b0;
        end else if (start_i) begin
            base_q  <= col_start_i;
            mask_q  <= dec_mask_i;
            order_q <= order_i;
            full_q  <= dec_full_i;
            bad_q   <= dec_bad_i;
        end
    end

    // Activity and beat counter, in priority order start > halt > step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
        end else if (active_q && halt_i) begin
            active_q <= 1'b0;
        end else if (active_q && step_i) begin
            if (at_end) begin
                active_q <= 1'b0;
            end else begin
                beat_q <= beat_q + BEAT_ONE;
            end
        end
    end

    assign active_o = active_q;
    assign beat_o   = beat_q;
    assign base_o   = base_q;
    assign mask_o   = mask_q;
    assign order_o  = order_q;
    assign full_o   = full_q;
    assign bad_o    = bad_q;
    assign last_o   = at_end;

    // R5: a fixed-length burst never counts past its wrap mask.
    assert_beat_in_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !full_q) |-> ((beat_q & ~mask_q) == '0));

    // R5: a step on the last beat leaves the block idle.
    assert_end_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && step_i && !halt_i && !start_i) |=> !active_q);

    // R7: a halt without a start leaves the block idle.
    assert_halt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && halt_i && !start_i) |=> !active_q);

    // R9: a reserved code always runs as a single beat.
    assert_bad_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && bad_q) |-> (at_end && beat_q == '0));

endmodule

// File: rtl/burst_addr_map.sv
// Module: burst_addr_map
// Forms the column of the current beat from the start column and the beat
// number. Bits inside the wrap mask come from either the sum or the XOR;
// bits outside it are copied from the start column. Combinational.
// Assumes the mask is contiguous from bit 0, so sum carries stay in range.
module burst_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             order_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] xor_mix;

    // Both candidate orderings, computed over the whole width.
    always_comb begin
        lin_sum = base_i + beat_i;
        xor_mix = base_i ^ beat_i;
    end

    // Per-bit select between the wrapping field and the fixed upper bits.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? (order_i ? xor_mix[b] : lin_sum[b])
                                    : base_i[b];
    end

endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen
// Top of the burst column address generator. It decodes the length code,
// holds the burst state and maps beat numbers to columns.
// Assumes the strobes are synchronous to clk. col_o is meaningful only while
// busy_o is 1.
module burst_col_gen #(
    parameter int COL_W  = 9,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  col_start_i,
    input  logic [CODE_W-1:0] len_sel_i,
    input  logic              xor_order_i,
    input  logic              step_i,
    input  logic              halt_i,
    output logic              busy_o,
    output logic [COL_W-1:0]  col_o,
    output logic              final_o,
    output logic              bad_len_o
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_bad;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask;
    logic             order;
    logic             full;

    burst_len_decode #(.COL_W(COL_W), .CODE_W(CODE_W)) u_dec (
        .code_i  (len_sel_i),
        .order_i (xor_order_i),
        .mask_o  (dec_mask),
        .full_o  (dec_full),
        .bad_o   (dec_bad)
    );

    burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .step_i      (step_i),
        .halt_i      (halt_i),
        .col_start_i (col_start_i),
        .order_i     (xor_order_i),
        .dec_mask_i  (dec_mask),
        .dec_full_i  (dec_full),
        .dec_bad_i   (dec_bad),
        .active_o    (busy_o),
        .beat_o      (beat),
        .base_o      (base),
        .mask_o      (mask),
        .order_o     (order),
        .full_o      (full),
        .bad_o       (bad_len_o),
        .last_o      (final_o)
    );

    burst_addr_map #(.COL_W(COL_W)) u_map (
        .base_i  (base),
        .beat_i  (beat),
        .mask_i  (mask),
        .order_i (order),
        .col_o   (col_o)
    );

    // R2 / R8: the cycle after any start shows its column as beat 0.
    assert_start_beat0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && col_o == $past(col_start_i)));

    // R3 / R4: bits outside the wrap field never move within a burst.
    assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_i && !halt_i && !start_i && !final_o && !full)
        |=> (((col_o ^ $past(col_o)) & ~$past(mask)) == '0));

    // R6: full-page bursts never flag a last beat.
    assert_page_no_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && full) |-> !final_o);

    // R10: with no strobe the current beat is held.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !step_i && !halt_i && !start_i) |=> (busy_o && $stable(col_o)));

    // R1: reset leaves the block idle and clean.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !final_o && !bad_len_o));

endmodule

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/100ps
module tb_burst_col_gen;

    localparam int COL_W  = 9;
    localparam int CODE_W = 3;
    localparam int NVEC   = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [COL_W-1:0]  col_start_i = '0;
    logic [CODE_W-1:0] len_sel_i = '0;
    logic              xor_order_i = 1'b0;
    logic              step_i = 1'b0;
    logic              halt_i = 1'b0;
    logic              busy_o;
    logic [COL_W-1:0]  col_o;
    logic              final_o;
    logic              bad_len_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W), .CODE_W(CODE_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_start_i(col_start_i),
        .len_sel_i(len_sel_i), .xor_order_i(xor_order_i), .step_i(step_i),
        .halt_i(halt_i), .busy_o(busy_o), .col_o(col_o), .final_o(final_o),
        .bad_len_o(bad_len_o)
    );

    typedef struct packed {
        logic [8:0] col;
        logic [2:0] code;
        logic       ord;
        logic [3:0] len;
        logic [8:0] last_col;
        logic       err;
    } vec_t;

    // start column, code, order, beats, column of the last beat, error flag
    localparam vec_t VECS [NVEC] = '{
        '{9'h0A5, 3'b010, 1'b0, 4'd4, 9'h0A4, 1'b0},
        '{9'h0A5, 3'b010, 1'b1, 4'd4, 9'h0A6, 1'b0},
        '{9'h1F6, 3'b011, 1'b0, 4'd8, 9'h1F5, 1'b0},
        '{9'h1F6, 3'b011, 1'b1, 4'd8, 9'h1F1, 1'b0},
        '{9'h033, 3'b001, 1'b0, 4'd2, 9'h032, 1'b0},
        '{9'h033, 3'b001, 1'b1, 4'd2, 9'h032, 1'b0},
        '{9'h100, 3'b000, 1'b0, 4'd1, 9'h100, 1'b0},
        '{9'h007, 3'b000, 1'b1, 4'd1, 9'h007, 1'b0},
        '{9'h0FF, 3'b011, 1'b0, 4'd8, 9'h0FE, 1'b0},
        '{9'h0FF, 3'b011, 1'b1, 4'd8, 9'h0F8, 1'b0},
        '{9'h055, 3'b100, 1'b0, 4'd1, 9'h055, 1'b1},
        '{9'h155, 3'b110, 1'b1, 4'd1, 9'h155, 1'b1},
        '{9'h012, 3'b111, 1'b1, 4'd1, 9'h012, 1'b1}
    };

    // Expected column of beat n, taken from the ordering rules in R3 and R4.
    function automatic logic [8:0] model_col(logic [8:0] s, logic [3:0] len,
                                             logic ord, int n);
        logic [8:0] m;
        logic [8:0] nn;
        m  = 9'(len) - 9'd1;
        nn = 9'(n);
        return ord ? ((s & ~m) | ((s ^ nn) & m))
                   : ((s & ~m) | ((s + nn) & m));
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive a start at the next falling edge; outputs show beat 0 on return.
    task automatic do_start(logic [8:0] c, logic [2:0] code, logic ord,
                            logic stp, logic hlt);
        @(negedge clk);
        start_i = 1'b1; col_start_i = c; len_sel_i = code; xor_order_i = ord;
        step_i = stp; halt_i = hlt;
        @(negedge clk);
        start_i = 1'b0; step_i = 1'b0; halt_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy after reset", 32'(busy_o), 0);
        check("R1", "final after reset", 32'(final_o), 0);
        check("R1", "bad after reset", 32'(bad_len_o), 0);
        rst_n = 1'b1;

        // Vector table: R2..R5 and R9
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            string rq;
            v = VECS[i];
            rq = v.err ? "R9" : (v.ord ? "R4" : "R3");
            do_start(v.col, v.code, v.ord, 1'b0, 1'b0);
            check("R2", "beat0 column", 32'(col_o), 32'(v.col));
            check("R9", "error flag", 32'(bad_len_o), 32'(v.err));
            for (int n = 0; n < int'(v.len); n++) begin
                check("R2", "busy in burst", 32'(busy_o), 1);
                check(rq, "beat column", 32'(col_o), 32'(model_col(v.col, v.len, v.ord, n)));
                check("R5", "final flag", 32'(final_o), 32'(n == int'(v.len) - 1));
                if (n == int'(v.len) - 1)
                    check(rq, "last beat column", 32'(col_o), 32'(v.last_col));
                step_i = 1'b1;
                @(negedge clk);
            end
            step_i = 1'b0;
            check("R5", "idle after last step", 32'(busy_o), 0);
        end

        // R6: full page wraps 511 -> 0 with no final flag
        do_start(9'h1FD, 3'b111, 1'b0, 1'b0, 1'b0);
        check("R9", "page code is valid", 32'(bad_len_o), 0);
        for (int n = 0; n < 5; n++) begin
            check("R6", "page column", 32'(col_o), 32'(9'(9'h1FD + 9'(n))));
            check("R6", "page final", 32'(final_o), 0);
            step_i = 1'b1;
            @(negedge clk);
        end
        // R10: hold with no strobe
        step_i = 1'b0;
        @(negedge clk);
        check("R10", "held column", 32'(col_o), 32'h002);
        check("R10", "held busy", 32'(busy_o), 1);
        // R7: halt beats step in the same cycle
        halt_i = 1'b1; step_i = 1'b1;
        @(negedge clk);
        halt_i = 1'b0; step_i = 1'b0;
        check("R7", "idle after halt+step", 32'(busy_o), 0);

        // R8: a start mid-burst with step and halt in the same cycle
        do_start(9'h040, 3'b011, 1'b0, 1'b0, 1'b0);
        step_i = 1'b1;
        @(negedge clk);
        do_start(9'h123, 3'b010, 1'b1, 1'b1, 1'b1);
        check("R8", "replaced busy", 32'(busy_o), 1);
        check("R8", "replaced column", 32'(col_o), 32'h123);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        check("R8", "replaced beat1 xor", 32'(col_o), 32'h122);

        // R8: a start in the middle of a full-page burst
        do_start(9'h0F0, 3'b111, 1'b0, 1'b0, 1'b0);
        step_i = 1'b1;
        @(negedge clk);
        do_start(9'h0A0, 3'b001, 1'b0, 1'b1, 1'b0);
        check("R8", "page replaced column", 32'(col_o), 32'h0A0);
        check("R8", "page replaced final", 32'(final_o), 0);

        // R9: error flag holds after the burst, then clears on a valid start
        do_start(9'h010, 3'b101, 1'b0, 1'b0, 1'b0);
        check("R9", "bad set", 32'(bad_len_o), 1);
        check("R9", "bad single final", 32'(final_o), 1);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        check("R9", "bad held when idle", 32'(bad_len_o), 1);
        do_start(9'h010, 3'b001, 1'b0, 1'b0, 1'b0);
        check("R9", "bad cleared", 32'(bad_len_o), 0);

        // R1: reset in the middle of a burst
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "busy after mid reset", 32'(busy_o), 0);
        check("R1", "final after mid reset", 32'(final_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule